// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This controller lets a small sequencer repeat a block of instructions a set number of times with no branch at the bottom of the block. When a loop instruction issues, the controller works out the iteration count, records the first body address (the loop instruction's address plus one) and the exit address (the loop instruction's address plus an end offset), and starts counting. From then on it watches the fetch address. Whenever the next sequential address would be the exit address, it either sends fetch back to the first body address or, on the last pass, lets fetch fall through to the exit address and drops its active flag.

The count comes from one of two places. With the immediate-select bit set, it is the 8-bit immediate plus one, so every immediate gives at least one pass and the largest gives 256. With the bit clear, it is the 16-bit register value taken as it is. A register value of zero starts no loop: fetch jumps straight to the exit address held from the most recent loop that was set up, and all held state stays unchanged.

The next-address output is combinational from the present fetch address, the issue inputs and the held state. The fetch stage registers it as its next address. Only one loop is tracked at a time. A loop instruction that issues while a loop is running replaces it.

Top module: `hwl_ctrl`

## Requirements
- R1: After reset the active flag is 0 and the held count, first-body address and exit address are all 0.
- R2: On issue with select = 1 the count is immediate + 1 (1 to 256) and the register input is ignored. With select = 0 the count is the 16-bit register value and the immediate is ignored.
- R3: On issue with a count of 0, next address = held exit address (0 if no loop has been set up since reset). The active flag and all held state keep their values.
- R4: On issue with a nonzero count, next address = issuing address + 1. The first-body address becomes issuing address + 1, the exit address becomes issuing address + offset, and the active flag reads 1 from the next cycle.
- R5: While active with no issue, if fetch address + 1 equals the exit address and more than one pass remains, next address = first-body address and the remaining count drops by one.
- R6: While active with no issue, if fetch address + 1 equals the exit address and exactly one pass remains, next address = exit address and the active flag reads 0 from the next cycle.
- R7: In every other cycle, next address = fetch address + 1, wrapping modulo 2^16.
- R8: The body runs exactly as many times as the resolved count, including 256 passes for immediate 255 and register counts above 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_i | input | 16 | Current fetch address |
| issue_i | input | 1 | A loop instruction is issuing at pc_i |
| imm_sel_i | input | 1 | 1: count from immediate; 0: count from register |
| imm_i | input | 8 | Immediate count field |
| reg_cnt_i | input | 16 | Register count value |
| end_ofs_i | input | 8 | Exit address offset from the loop instruction |
| next_pc_o | output | 16 | Address to fetch next |
| active_o | output | 1 | A loop is in progress |

## Verification
The hardest condition to reach from the ports is the last-pass exit after a long count. The counter has to go down through every value, and the bench must show that both the 256th pass of an immediate loop and a register count above 255 exit on exactly the right cycle. The stimulus reaches it by acting as the fetch stage for the whole loop, walking every body address on every pass, and by using a single-instruction body so that a redirect is requested on every cycle. The skip case is then run against an exit address that an earlier loop left behind. This shows that a zero count jumps to the held value and does not disturb the active flag.

// File: rtl/hwl_pkg.sv
package hwl_pkg;

    // Kind of address decision taken in one cycle
    typedef enum logic [2:0] {
        STEP_SEQ   = 3'd0,
        STEP_START = 3'd1,
        STEP_SKIP  = 3'd2,
        STEP_WRAP  = 3'd3,
        STEP_EXIT  = 3'd4
    } step_e;

endpackage

// File: rtl/hwl_count_sel.sv
module hwl_count_sel #(
    parameter int IMM_W = 8,
    parameter int REG_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             imm_sel_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [REG_W-1:0] reg_cnt_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o
);
    logic [CNT_W-1:0] imm_cnt;
    logic [CNT_W-1:0] reg_cnt;

    // immediate form is biased by one so that it never yields zero
    assign imm_cnt = CNT_W'(imm_i) + CNT_W'(1);
    assign reg_cnt = CNT_W'(reg_cnt_i);
    assign cnt_o   = imm_sel_i ? imm_cnt : reg_cnt;
    assign zero_o  = (cnt_o == '0);

    always_comb begin
        if (imm_sel_i) a_r2_imm_nonzero : assert (!zero_o);
    end
endmodule

// File: rtl/hwl_step_decide.sv
module hwl_step_decide
    import hwl_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int CNT_W = 16
) (
    input  logic             issue_i,
    input  logic             new_zero_i,
    input  logic             active_i,
    input  logic [PC_W-1:0]  seq_pc_i,
    input  logic [PC_W-1:0]  lend_i,
    input  logic [CNT_W-1:0] cnt_i,
    output step_e            step_o
);
    logic at_end;
    logic last_pass;

    assign at_end    = active_i && (seq_pc_i == lend_i);
    assign last_pass = (cnt_i == CNT_W'(1));

    always_comb begin
        step_o = STEP_SEQ;
        if (issue_i) begin
            step_o = new_zero_i ? STEP_SKIP : STEP_START;
        end else if (at_end) begin
            step_o = last_pass ? STEP_EXIT : STEP_WRAP;
        end
    end
endmodule

// File: rtl/hwl_ctrl.sv
module hwl_ctrl
    import hwl_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int IMM_W = 8,
    parameter int REG_W = 16,
    parameter int OFS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  pc_i,
    input  logic             issue_i,
    input  logic             imm_sel_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [REG_W-1:0] reg_cnt_i,
    input  logic [OFS_W-1:0] end_ofs_i,
    output logic [PC_W-1:0]  next_pc_o,
    output logic             active_o
);
    localparam int CNT_W = (REG_W > IMM_W) ? REG_W : IMM_W + 1;

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic [PC_W-1:0]  top;
        logic [PC_W-1:0]  lend;
    } loop_st_t;

    loop_st_t         st_q, st_d;
    logic [PC_W-1:0]  next_pc_d;
    logic [PC_W-1:0]  seq_pc;
    logic [CNT_W-1:0] new_cnt;
    logic             new_zero;
    step_e            step;

    assign seq_pc = pc_i + PC_W'(1);

    hwl_count_sel #(
        .IMM_W(IMM_W),
        .REG_W(REG_W),
        .CNT_W(CNT_W)
    ) u_count (
        .imm_sel_i (imm_sel_i),
        .imm_i     (imm_i),
        .reg_cnt_i (reg_cnt_i),
        .cnt_o     (new_cnt),
        .zero_o    (new_zero)
    );

    hwl_step_decide #(
        .PC_W (PC_W),
        .CNT_W(CNT_W)
    ) u_step (
        .issue_i    (issue_i),
        .new_zero_i (new_zero),
        .active_i   (st_q.active),
        .seq_pc_i   (seq_pc),
        .lend_i     (st_q.lend),
        .cnt_i      (st_q.cnt),
        .step_o     (step)
    );

    always_comb begin
        st_d      = st_q;
        next_pc_d = seq_pc;
        unique case (step)
            STEP_START: begin
                st_d.active = 1'b1;
                st_d.cnt    = new_cnt;
                st_d.top    = seq_pc;
                st_d.lend   = pc_i + PC_W'(end_ofs_i);
                next_pc_d   = seq_pc;
            end
            STEP_SKIP: begin
                next_pc_d = st_q.lend;
            end
            STEP_WRAP: begin
                st_d.cnt  = st_q.cnt - CNT_W'(1);
                next_pc_d = st_q.top;
            end
            STEP_EXIT: begin
                st_d.cnt    = '0;
                st_d.active = 1'b0;
                next_pc_d   = st_q.lend;
            end
            default: begin
                next_pc_d = seq_pc;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign next_pc_o = next_pc_d;
    assign active_o  = st_q.active;

    // R4: a nonzero issue arms the loop with bounds from the issuing address
    a_r4_arm : assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && !new_zero |=> st_q.active && (st_q.top == $past(seq_pc)));

    // R3: a zero count leaves the active flag and bounds untouched
    a_r3_skip_hold : assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && new_zero |=> $stable(st_q.active) && $stable(st_q.lend));

    // R5: a wrap consumes exactly one pass and stays active
    a_r5_wrap_dec : assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i && st_q.active && (seq_pc == st_q.lend) && (st_q.cnt > CNT_W'(1))
        |=> st_q.active && (st_q.cnt == $past(st_q.cnt) - CNT_W'(1)));

    // R6: the final pass clears the active flag
    a_r6_exit : assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i && st_q.active && (seq_pc == st_q.lend) && (st_q.cnt == CNT_W'(1))
        |=> !st_q.active);

    // R8: an active loop always has passes remaining
    a_r8_cnt_live : assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (st_q.cnt != '0));

    // R7: with no issue and no loop, fetch just steps forward
    a_r7_seq : assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i && !st_q.active |-> (next_pc_o == seq_pc));
endmodule

// File: tb/tb_hwl_ctrl.sv
module tb_hwl_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pc_i = '0;
    logic        issue_i = 1'b0;
    logic        imm_sel_i = 1'b0;
    logic [7:0]  imm_i = '0;
    logic [15:0] reg_cnt_i = '0;
    logic [7:0]  end_ofs_i = '0;
    logic [15:0] next_pc_o;
    logic        active_o;

    always #2.5 clk = ~clk;

    hwl_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .issue_i(issue_i),
        .imm_sel_i(imm_sel_i), .imm_i(imm_i), .reg_cnt_i(reg_cnt_i),
        .end_ofs_i(end_ofs_i), .next_pc_o(next_pc_o), .active_o(active_o)
    );

    logic [15:0] exp_pc_q[$];
    logic        exp_act_q[$];
    string       exp_tag_q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    logic [15:0] model_end = '0;   // bench-side exit address after reset (R1)
    bit          done = 1'b0;

    // monitor: compares outputs at the falling edge, mid-cycle
    always @(negedge clk) begin
        if (exp_pc_q.size() > 0) begin
            logic [15:0] ep;
            logic        ea;
            string       tg;
            ep = exp_pc_q.pop_front();
            ea = exp_act_q.pop_front();
            tg = exp_tag_q.pop_front();
            n_chk++;
            if (next_pc_o !== ep || active_o !== ea) begin
                n_fail++;
                $display("FAIL %s pc_in=%h: next_pc=%h active=%b expected next_pc=%h active=%b",
                         tg, pc_i, next_pc_o, active_o, ep, ea);
            end
        end
    end

    task automatic drive(input logic [15:0] pc, input logic iss, input logic sel,
                         input logic [7:0] imm, input logic [15:0] rv, input logic [7:0] ofs,
                         input logic [15:0] ep, input logic ea, input string tg);
        @(posedge clk);
        #1;
        pc_i = pc; issue_i = iss; imm_sel_i = sel; imm_i = imm;
        reg_cnt_i = rv; end_ofs_i = ofs;
        exp_pc_q.push_back(ep);
        exp_act_q.push_back(ea);
        exp_tag_q.push_back(tg);
    endtask

    // plays the fetch stage through a whole loop and pushes expected results
    task automatic run_loop(input logic [15:0] a, input logic [7:0] ofs, input logic sel,
                            input logic [7:0] imm, input logic [15:0] rv, input string tg);
        int n;
        logic [15:0] lend;
        n = sel ? int'(imm) + 1 : int'(rv);
        if (n == 0) begin
            drive(a, 1'b1, sel, imm, rv, ofs, model_end, 1'b0, {tg, " R3 skip"});
            return;
        end
        lend = a + 16'(ofs);
        drive(a, 1'b1, sel, imm, rv, ofs, a + 16'd1, 1'b0, {tg, " R4 start"});
        model_end = lend;
        for (int it = 0; it < n; it++) begin
            for (int p = 1; p < int'(ofs); p++) begin
                logic [15:0] cur;
                logic [15:0] ep;
                cur = a + 16'(p);
                if (cur + 16'd1 != lend) ep = cur + 16'd1;
                else if (it == n - 1)    ep = lend;
                else                     ep = a + 16'd1;
                // inputs other than pc are junk while not issuing
                drive(cur, 1'b0, ~sel, imm ^ 8'h5a, rv ^ 16'h00f0, ofs ^ 8'h01, ep, 1'b1,
                      (cur + 16'd1 == lend) ? ((it == n - 1) ? {tg, " R6 R8 exit"} : {tg, " R5 wrap"})
                                            : {tg, " R7 body"});
            end
        end
        drive(lend, 1'b0, 1'b0, 8'h00, 16'h0000, 8'h00, lend + 16'd1, 1'b0, {tg, " R6 after"});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 R7: reset state, sequential step
        drive(16'h0005, 1'b0, 1'b0, 8'h00, 16'h0000, 8'h00, 16'h0006, 1'b0, "R1 R7 reset");
        drive(16'hffff, 1'b0, 1'b0, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b0, "R7 wrap16");
        // R3: zero register count right after reset jumps to exit 0
        run_loop(16'h0020, 8'd4, 1'b0, 8'h33, 16'h0000, "R1 R3 zero-after-reset");
        // R2: immediate 0 -> one pass, register ignored
        run_loop(16'h0030, 8'd4, 1'b1, 8'h00, 16'h0007, "R2 imm0");
        // R4 R5: immediate 2 -> three passes, three-instruction body
        run_loop(16'h0040, 8'd4, 1'b1, 8'h02, 16'h0000, "R4 R5 imm2");
        // R2 R3: zero register count, immediate ignored, held exit 0x44
        run_loop(16'h0080, 8'd5, 1'b0, 8'h09, 16'h0000, "R2 R3 held-exit");
        // R2: register count 3
        run_loop(16'h0090, 8'd3, 1'b0, 8'h00, 16'h0003, "R2 reg3");
        // R8: immediate 255 -> 256 passes, one-instruction body
        run_loop(16'h0100, 8'd2, 1'b1, 8'hff, 16'h0001, "R8 imm255");
        // R8: 16-bit register count 1000
        run_loop(16'h0200, 8'd3, 1'b0, 8'h00, 16'd1000, "R2 R8 reg1000");
        // R3: skip now lands on the exit of the last loop (0x203)
        run_loop(16'h0300, 8'd6, 1'b0, 8'h00, 16'h0000, "R3 held-exit2");
        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule